// File: doc/BRIEF.md
# Load/Store Address Generator with Base Writeback

This block computes, for one load or store, the address to present to memory and the value the base register should take afterwards. It takes a base register value and an offset. The offset is either a 12-bit immediate from the instruction or a second register value shifted left by an amount the instruction supplies. A direction bit selects whether the offset is added to or subtracted from the base.

A two-bit indexing code chooses among three variants. The plain-offset variant uses the adjusted address and leaves the base alone. The pre-indexed variant uses the adjusted address and also writes it back. The post-indexed variant uses the untouched base as the address and writes back the adjusted value.

Results are registered and appear one cycle after a valid request. A pipeline stage that drives a memory port and a register-file write port would normally sit behind it.

Top module: `ls_addr_gen`

## Requirements
- R1: While `rst_n` is low, and after reset until the first valid request, `out_valid`, `wb_en`, `mem_addr` and `base_next` are all zero.
- R2: `out_valid` equals the value `in_valid` had one clock earlier, and the outputs of a request appear on the clock edge after the one that accepts it.
- R3: Indexing code 0 (plain offset): `mem_addr` = base ± offset, `base_next` = base unchanged, `wb_en` = 0.
- R4: Indexing code 1 (pre-index): `mem_addr` = base ± offset, `base_next` = that same address, `wb_en` = 1.
- R5: Indexing code 2 (post-index): `mem_addr` = base unchanged, `base_next` = base ± offset, `wb_en` = 1.
- R6: Indexing code 3 behaves exactly as code 0: adjusted address, base kept, no writeback.
- R7: With `use_reg` = 0 the offset is `imm_in` zero-extended to 32 bits, and `reg_in` and `shamt_in` have no effect on the outputs.
- R8: With `use_reg` = 1 the offset is `reg_in` shifted left logically by `shamt_in` (0 to 31), and bits moved past bit 31 are lost.
- R9: `add_dir` = 1 adds the offset to the base, and `add_dir` = 0 subtracts it. Both wrap modulo 2^32.
- R10: A cycle with `in_valid` low produces `out_valid` = 0 and `wb_en` = 0 on the next edge, and `mem_addr` and `base_next` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| base_in | input | 32 | Base register value |
| imm_in | input | 12 | Unsigned immediate offset |
| reg_in | input | 32 | Offset register value |
| shamt_in | input | 5 | Left-shift amount for the register offset |
| use_reg | input | 1 | 1: register offset, 0: immediate offset |
| add_dir | input | 1 | 1: add offset, 0: subtract offset |
| mode_in | input | 2 | Indexing code: 0 offset, 1 pre-index, 2 post-index, 3 as 0 |
| out_valid | output | 1 | Results valid |
| mem_addr | output | 32 | Address for the memory access |
| base_next | output | 32 | Value to write to the base register |
| wb_en | output | 1 | Base register write enable |

## Verification
The only state is the output register. A fault in the offset selection, the shifter or the adder shows up as a wrong `mem_addr` or `base_next` in the cycle right after the request. For the post-indexed variant it shows only on `base_next`. A swapped variant selection shows up within one cycle as a misplaced sum or a wrong `wb_en`. A faulty hold path shows up in the first idle cycle after a valid request.

// File: rtl/ls_addr_pkg.sv
package ls_addr_pkg;

  typedef enum logic [1:0] {
    IDX_OFFSET = 2'd0,
    IDX_PRE    = 2'd1,
    IDX_POST   = 2'd2,
    IDX_RSVD   = 2'd3
  } idx_mode_e;

  // Logical left shift of a register offset; bits past the top are lost.
  function automatic logic [31:0] scale_offset(input logic [31:0] val,
                                               input logic [4:0]  amt);
    return val << amt;
  endfunction

  // Base adjusted by offset, modulo 2^32.
  function automatic logic [31:0] adjust_base(input logic [31:0] base,
                                              input logic [31:0] off,
                                              input logic        do_add);
    return do_add ? (base + off) : (base - off);
  endfunction

endpackage

// File: rtl/ls_off_sel.sv
module ls_off_sel #(
  parameter int DW = 32,
  parameter int IW = 12,
  parameter int SW = 5
) (
  input  logic [IW-1:0] imm,
  input  logic [DW-1:0] rval,
  input  logic [SW-1:0] sh,
  input  logic          use_reg,
  output logic [DW-1:0] off
);
  import ls_addr_pkg::*;

  logic [DW-1:0] imm_ext;
  logic [DW-1:0] reg_scaled;

  generate
    if (IW < DW) begin : g_zext
      assign imm_ext = {{(DW-IW){1'b0}}, imm};
    end else begin : g_full
      assign imm_ext = imm[DW-1:0];
    end
  endgenerate

  assign reg_scaled = rval << sh;
  assign off        = use_reg ? reg_scaled : imm_ext;

endmodule

// File: rtl/ls_adder.sv
module ls_adder #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] off,
  input  logic          do_add,
  output logic [DW-1:0] sum
);
  assign sum = do_add ? (base + off) : (base - off);
endmodule

// File: rtl/ls_wb_pick.sv
module ls_wb_pick #(
  parameter int DW = 32
) (
  input  ls_addr_pkg::idx_mode_e mode,
  input  logic [DW-1:0]          base,
  input  logic [DW-1:0]          sum,
  output logic [DW-1:0]          addr,
  output logic [DW-1:0]          nbase,
  output logic                   wb
);
  import ls_addr_pkg::*;

  always_comb begin
    unique case (mode)
      IDX_PRE: begin
        addr  = sum;
        nbase = sum;
        wb    = 1'b1;
      end
      IDX_POST: begin
        addr  = base;
        nbase = sum;
        wb    = 1'b1;
      end
      default: begin
        addr  = sum;
        nbase = base;
        wb    = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen #(
  parameter int DW = 32,
  parameter int IW = 12,
  parameter int SW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] base_in,
  input  logic [IW-1:0] imm_in,
  input  logic [DW-1:0] reg_in,
  input  logic [SW-1:0] shamt_in,
  input  logic          use_reg,
  input  logic          add_dir,
  input  logic [1:0]    mode_in,
  output logic          out_valid,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] base_next,
  output logic          wb_en
);
  import ls_addr_pkg::*;

  // Named intermediate results, visible to the checker.
  logic [DW-1:0] off_val;
  logic [DW-1:0] sum_val;
  logic [DW-1:0] pick_addr;
  logic [DW-1:0] pick_base;
  logic          pick_wb;
  idx_mode_e     mode_e;

  assign mode_e = idx_mode_e'(mode_in);

  ls_off_sel #(.DW(DW), .IW(IW), .SW(SW)) u_off (
    .imm(imm_in), .rval(reg_in), .sh(shamt_in), .use_reg(use_reg), .off(off_val)
  );

  ls_adder #(.DW(DW)) u_add (
    .base(base_in), .off(off_val), .do_add(add_dir), .sum(sum_val)
  );

  ls_wb_pick #(.DW(DW)) u_pick (
    .mode(mode_e), .base(base_in), .sum(sum_val),
    .addr(pick_addr), .nbase(pick_base), .wb(pick_wb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wb_en     <= 1'b0;
      mem_addr  <= '0;
      base_next <= '0;
    end else begin
      out_valid <= in_valid;
      wb_en     <= in_valid & pick_wb;
      if (in_valid) begin
        mem_addr  <= pick_addr;
        base_next <= pick_base;
      end
    end
  end

endmodule

// File: rtl/ls_addr_gen_chk.sv
module ls_addr_gen_chk #(
  parameter int DW = 32,
  parameter int IW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [DW-1:0] base_in,
  input logic          use_reg,
  input logic [1:0]    mode_in,
  input logic [DW-1:0] off_val,
  input logic          out_valid,
  input logic [DW-1:0] mem_addr,
  input logic [DW-1:0] base_next,
  input logic          wb_en
);

  a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r10_wb_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> out_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(mem_addr) && $stable(base_next)));

  // R3 and R6: the plain-offset codes keep the base.
  a_r3_base_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mode_in == 2'd0 || mode_in == 2'd3))
      |=> (!wb_en && base_next == $past(base_in)));

  a_r4_pre_same: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_in == 2'd1) |=> (wb_en && base_next == mem_addr));

  a_r5_post_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_in == 2'd2) |=> (wb_en && mem_addr == $past(base_in)));

  a_r7_imm_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !use_reg) |-> (off_val >> IW) == '0);

endmodule

bind ls_addr_gen ls_addr_gen_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base_in(base_in),
  .use_reg(use_reg), .mode_in(mode_in), .off_val(off_val),
  .out_valid(out_valid), .mem_addr(mem_addr), .base_next(base_next),
  .wb_en(wb_en)
);

// File: tb/sim_ls_addr_gen.sv
module sim_ls_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] base_in = '0;
  logic [11:0] imm_in = '0;
  logic [31:0] reg_in = '0;
  logic [4:0]  shamt_in = '0;
  logic        use_reg = 1'b0;
  logic        add_dir = 1'b0;
  logic [1:0]  mode_in = '0;
  logic        out_valid;
  logic [31:0] mem_addr;
  logic [31:0] base_next;
  logic        wb_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Reference state.
  longint e_addr = 0;
  longint e_base = 0;
  bit     e_wb   = 1'b0;
  bit     e_v    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ls_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base_in(base_in),
    .imm_in(imm_in), .reg_in(reg_in), .shamt_in(shamt_in), .use_reg(use_reg),
    .add_dir(add_dir), .mode_in(mode_in), .out_valid(out_valid),
    .mem_addr(mem_addr), .base_next(base_next), .wb_en(wb_en)
  );

  localparam longint MOD = 64'h1_0000_0000;

  task automatic cmp(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One request (or idle cycle); inputs set at a falling edge, results read at the next one.
  task automatic step(string tag, bit v, longint b, int imm, longint r, int sh,
                      bit ureg, bit dir, int md);
    longint off, adj;
    in_valid = v; base_in = b[31:0]; imm_in = imm[11:0]; reg_in = r[31:0];
    shamt_in = sh[4:0]; use_reg = ureg; add_dir = dir; mode_in = md[1:0];
    if (ureg) off = (r * (longint'(1) << sh)) % MOD;
    else      off = imm;
    if (dir) adj = (b + off) % MOD;
    else     adj = (b - off + MOD) % MOD;
    e_v  = v;
    e_wb = 1'b0;
    if (v) begin
      case (md)
        1: begin e_addr = adj; e_base = adj; e_wb = 1'b1; end
        2: begin e_addr = b;   e_base = adj; e_wb = 1'b1; end
        default: begin e_addr = adj; e_base = b; end
      endcase
    end
    @(negedge clk);
    cmp(tag, "out_valid", longint'(out_valid), longint'(e_v));
    cmp(tag, "wb_en", longint'(wb_en), longint'(e_wb));
    cmp(tag, "mem_addr", longint'(mem_addr), e_addr);
    cmp(tag, "base_next", longint'(base_next), e_base);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp("R1", "out_valid", longint'(out_valid), 0);
    cmp("R1", "wb_en", longint'(wb_en), 0);
    cmp("R1", "mem_addr", longint'(mem_addr), 0);
    cmp("R1", "base_next", longint'(base_next), 0);
    rst_n = 1'b1;
    step("R1", 0, 0, 0, 0, 0, 0, 0, 0);

    // R3 offset, immediate add
    step("R3", 1, 32'h1000, 12'h024, 0, 0, 0, 1, 0);
    // R4 pre-index, immediate subtract
    step("R4", 1, 32'h2000, 12'h010, 0, 0, 0, 0, 1);
    // R5 post-index, immediate add
    step("R5", 1, 32'h3000, 12'hFFF, 0, 0, 0, 1, 2);
    // R6 reserved code behaves as offset
    step("R6", 1, 32'h4000, 12'h008, 0, 0, 0, 0, 3);
    // R10 idle: hold
    step("R10", 0, 32'hDEAD, 12'h123, 32'h55, 3, 1, 1, 1);
    step("R10", 0, 32'hBEEF, 12'h456, 32'h66, 4, 0, 0, 2);
    // R7 immediate ignores reg_in and shamt_in
    step("R7", 1, 32'h100, 12'h004, 32'hFFFF_FFFF, 31, 0, 1, 1);
    // R8 register offset with shift, bits lost past 31
    step("R8", 1, 32'h0, 0, 32'h8000_0003, 1, 1, 1, 1);
    step("R8", 1, 32'h10, 0, 32'h0000_0003, 31, 1, 1, 2);
    step("R8", 1, 32'h10, 0, 32'h0000_0005, 0, 1, 0, 0);
    // R9 wraparound both ways
    step("R9", 1, 32'h0000_0004, 12'h008, 0, 0, 0, 0, 1);
    step("R9", 1, 32'hFFFF_FFF0, 0, 32'h1, 5, 1, 1, 2);
    // R2 back-to-back and gap
    step("R2", 1, 32'h500, 12'h001, 0, 0, 0, 1, 1);
    step("R2", 0, 32'h0, 0, 0, 0, 0, 0, 0);

    // Mixed patterns across all codes
    for (int i = 0; i < 400; i++) begin
      int md = i % 4;
      string tg;
      tg = (md == 0) ? "R3" : (md == 1) ? "R4" : (md == 2) ? "R5" : "R6";
      step(tg, ($urandom % 5) != 0, longint'($urandom), int'($urandom % 4096),
           longint'($urandom), int'($urandom % 32), $urandom % 2, $urandom % 2, md);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule